// File: doc/BRIEF.md
# Thread Block Warp Dispatcher

This block turns a one-dimensional thread-block launch into a stream of warp descriptors. A launch names the block's position in the grid, the number of threads in the block, and the element count that bounds the useful work. The dispatcher cuts the block into warps of consecutive thread IDs and offers one descriptor per cycle on a valid/ready handshake.

Each descriptor carries the warp's number within the block, the global index of every lane, and an activity mask. A lane is active only when it exists inside the block and its global index falls below the element count. Warps in which the bounds check splits the existing lanes into active and inactive groups are flagged as divergent, so that a downstream scheduler can see in advance which warps will run both paths of the guard. A marker on the last warp of the block tells the consumer that the launch is finished. The lane count per warp is a parameter.

Top module: `warp_dispatch`

## Requirements
- R1: After reset `launch_ready` is 1 and `wd_valid` is 0.
- R2: A launch is accepted only on a cycle where `launch_valid` and `launch_ready` are both 1. `launch_ready` is 0 while descriptors of the current launch are pending, and a launch offered during that time is ignored: the descriptor stream of the current launch continues unchanged.
- R3: A launch with thread count D > 0 produces ceil(D / LANES) descriptors. The first is offered on the cycle after acceptance, with `wd_warp` = 0, and each later one carries the previous warp number plus 1. The next one is offered on the cycle after each accepted descriptor.
- R4: Lane l of warp w reports global index blk*D + w*LANES + l in bits [l*IDX_W +: IDX_W] of `wd_gidx`.
- R5: Bit l of `wd_mask` is 1 only when w*LANES + l < D and that lane's global index is below `launch_count`. A warp in which no lane qualifies is still offered, with an all-zero mask.
- R6: `wd_diverge` is 1 only when, among the lanes with w*LANES + l < D, at least one is active and at least one is inactive.
- R7: `wd_last` is 1 exactly on the descriptor with `wd_warp` = ceil(D / LANES) - 1.
- R8: While `wd_valid` is 1 and `wd_ready` is 0, every descriptor output holds its value into the next cycle.
- R9: A launch with D = 0 is accepted, produces no descriptor, and leaves `launch_ready` at 1 on the next cycle.
- R10: On the cycle after the last descriptor is accepted, `wd_valid` is 0 and `launch_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Launch request present |
| launch_ready | output | 1 | Dispatcher idle and able to take a launch |
| launch_blk | input | IDX_W | Block position in the x dimension |
| launch_dim | input | DIM_W | Threads in the block |
| launch_count | input | IDX_W | Element count; lanes at or above it are inactive |
| wd_valid | output | 1 | Descriptor offered |
| wd_ready | input | 1 | Consumer takes the descriptor |
| wd_warp | output | DIM_W | Warp number within the block |
| wd_gidx | output | LANES*IDX_W | Global index of each lane, lane 0 in the low bits |
| wd_mask | output | LANES | Active lanes |
| wd_diverge | output | 1 | Existing lanes split by the bounds check |
| wd_last | output | 1 | Final warp of the block |

## Verification
The assertions take for granted that blk*D + D fits in IDX_W bits, so that no lane index wraps, and that the consumer's ready may change freely from cycle to cycle. The random launches draw block position and size so that this product stays well inside 16 bits, and place the element count near the block's index range so that full, empty and split warps all occur. Ready is toggled at random, and junk launches are offered while the dispatcher is busy to exercise the ignore path.

// File: rtl/warp_dispatch.sv
module warp_dispatch #(
  parameter int LANES = 32,
  parameter int IDX_W = 16,
  parameter int DIM_W = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   launch_valid,
  output logic                   launch_ready,
  input  logic [IDX_W-1:0]       launch_blk,
  input  logic [DIM_W-1:0]       launch_dim,
  input  logic [IDX_W-1:0]       launch_count,
  output logic                   wd_valid,
  input  logic                   wd_ready,
  output logic [DIM_W-1:0]       wd_warp,
  output logic [LANES*IDX_W-1:0] wd_gidx,
  output logic [LANES-1:0]       wd_mask,
  output logic                   wd_diverge,
  output logic                   wd_last
);

  localparam int LW  = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int TW  = DIM_W + LW;

  logic             busy_q;
  logic [IDX_W-1:0] base_q;
  logic [IDX_W-1:0] cnt_q;
  logic [DIM_W-1:0] dim_q;
  logic [DIM_W-1:0] warp_q;
  logic [DIM_W-1:0] top_q;

  logic [LANES-1:0] in_blk;
  logic [LANES-1:0] act;

  wire take_launch = launch_valid && launch_ready;
  wire take_desc   = wd_valid && wd_ready;
  wire [DIM_W-1:0] dim_m1 = launch_dim - 1'b1;
  wire [IDX_W-1:0] prod   = launch_blk * IDX_W'(launch_dim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      dim_q  <= '0;
      warp_q <= '0;
      top_q  <= '0;
    end else if (take_launch) begin
      busy_q <= (launch_dim != '0);
      base_q <= prod;
      cnt_q  <= launch_count;
      dim_q  <= launch_dim;
      warp_q <= '0;
      top_q  <= DIM_W'(dim_m1 >> LW);
    end else if (take_desc) begin
      if (warp_q == top_q) busy_q <= 1'b0;
      else                 warp_q <= warp_q + 1'b1;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [TW-1:0]    tid;
    logic [IDX_W-1:0] g;
    assign tid       = TW'(warp_q) * TW'(LANES) + TW'(l);
    assign g         = base_q + IDX_W'(tid);
    assign in_blk[l] = tid < TW'(dim_q);
    assign act[l]    = in_blk[l] && (g < cnt_q);
    assign wd_gidx[l*IDX_W +: IDX_W] = g;
  end

  assign launch_ready = !busy_q;
  assign wd_valid     = busy_q;
  assign wd_warp      = warp_q;
  assign wd_mask      = act;
  assign wd_diverge   = (|act) && (|(in_blk & ~act));
  assign wd_last      = busy_q && (warp_q == top_q);

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_valid && !wd_ready |=> wd_valid && $stable(wd_warp) && $stable(wd_gidx)
                              && $stable(wd_mask) && $stable(wd_last));

  // R3
  first_warp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_launch && launch_dim != '0 |=> wd_valid && wd_warp == '0);

  // R3
  warp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_desc && !wd_last |=> wd_valid && wd_warp == $past(wd_warp) + 1'b1);

  // R10
  drain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_desc && wd_last |=> launch_ready && !wd_valid);

  // R9
  empty_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_launch && launch_dim == '0 |=> launch_ready && !wd_valid);

  // R6
  diverge_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_diverge |-> wd_mask != '0 && wd_mask != '1);

endmodule

// File: tb/warp_dispatch_tb_top.sv
module warp_dispatch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 32;
  localparam int IDX_W = 16;
  localparam int DIM_W = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic launch_valid = 0;
  logic launch_ready;
  logic [IDX_W-1:0] launch_blk = '0;
  logic [DIM_W-1:0] launch_dim = '0;
  logic [IDX_W-1:0] launch_count = '0;
  logic wd_valid;
  logic wd_ready = 0;
  logic [DIM_W-1:0] wd_warp;
  logic [LANES*IDX_W-1:0] wd_gidx;
  logic [LANES-1:0] wd_mask;
  logic wd_diverge;
  logic wd_last;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  warp_dispatch #(.LANES(LANES), .IDX_W(IDX_W), .DIM_W(DIM_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .launch_valid(launch_valid), .launch_ready(launch_ready),
    .launch_blk(launch_blk), .launch_dim(launch_dim), .launch_count(launch_count),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_warp(wd_warp),
    .wd_gidx(wd_gidx), .wd_mask(wd_mask), .wd_diverge(wd_diverge), .wd_last(wd_last)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [LANES*IDX_W-1:0] exp_gidx(int blk, int dim, int w);
    logic [LANES*IDX_W-1:0] r;
    for (int l = 0; l < LANES; l++) r[l*IDX_W +: IDX_W] = IDX_W'(blk*dim + w*LANES + l);
    return r;
  endfunction

  function automatic logic [LANES-1:0] exp_mask(int blk, int dim, int n, int w);
    logic [LANES-1:0] r;
    for (int l = 0; l < LANES; l++) begin
      int t = w*LANES + l;
      r[l] = (t < dim) && (blk*dim + t < n);
    end
    return r;
  endfunction

  function automatic bit exp_div(int blk, int dim, int n, int w);
    bit on = 0, off = 0;
    for (int l = 0; l < LANES; l++) begin
      int t = w*LANES + l;
      if (t < dim) begin
        if (blk*dim + t < n) on = 1; else off = 1;
      end
    end
    return on && off;
  endfunction

  task automatic run_launch(input int blk, input int dim, input int n);
    int nw = (dim + LANES - 1) / LANES;
    int w = 0;
    @(negedge clk);
    chk("R2 ready when idle", launch_ready, 1);
    launch_valid = 1; launch_blk = IDX_W'(blk); launch_dim = DIM_W'(dim); launch_count = IDX_W'(n);
    @(negedge clk);
    launch_valid = 0;
    if (dim == 0) begin
      chk("R9 ready after empty launch", launch_ready, 1);
      chk("R9 no descriptor", wd_valid, 0);
      return;
    end
    while (w < nw && !done) begin
      bit rdy = ($urandom % 3) != 0;
      chk("R3 valid", wd_valid, 1);
      chk("R2 busy not ready", launch_ready, 0);
      chk("R3 warp number", wd_warp, w);
      chk("R4 gidx", (wd_gidx == exp_gidx(blk, dim, w)), 1);
      chk("R5 mask", wd_mask, exp_mask(blk, dim, n, w));
      chk("R6 diverge", wd_diverge, exp_div(blk, dim, n, w));
      chk("R7 last", wd_last, (w == nw - 1));
      wd_ready = rdy;
      launch_valid = $urandom % 2;
      launch_blk = IDX_W'($urandom); launch_dim = DIM_W'($urandom); launch_count = IDX_W'($urandom);
      @(negedge clk);
      launch_valid = 0;
      if (rdy) w++;
      else chk("R8 hold warp", wd_warp, w);
    end
    wd_ready = 0;
    chk("R10 idle after last", launch_ready, 1);
    chk("R10 no valid after last", wd_valid, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk("R1 ready at reset", launch_ready, 1);
    chk("R1 valid at reset", wd_valid, 0);
    rst_n = 1;
    run_launch(0, 64, 60);
    run_launch(2, 128, 1000);
    run_launch(1, 40, 5000);
    run_launch(3, 100, 0);
    run_launch(0, 0, 10);
    run_launch(7, 1, 8);
    run_launch(5, 96, 5*96 + 64);
    run_launch(4, 33, 4*33 + 32);
    for (int i = 0; i < 40 && !done; i++) begin
      int dim = $urandom % 301;
      int blk = $urandom % 100;
      int n = blk*dim + int'($urandom % (dim + 41)) - 20;
      if (n < 0) n = 0;
      run_launch(blk, dim, n);
    end
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wait (cyc > 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule